// File: doc/BRIEF.md
# I2C Slave Receive Engine with Clock Stretching

This block is the receive half of an I2C target. It synchronises the bus lines into the core clock and detects START and STOP conditions. It shifts in the address byte and compares the 7-bit address against three programmable address slots, the general-call address and the host address. When the address matches and the transfer is a master write, it acknowledges each byte with a software-chosen ACK level and hands every byte to software through a one-byte holding register guarded by a full flag.

Software polls the match flags, the full flag and a sticky STOP flag. It reads the holding register with a one-cycle read strobe. If software falls behind, the block holds SCL low before the byte that would overrun the register completes, and it lets SCL go when the register is read. The first byte software sees after an address match is the address byte itself. Both bus lines are driven only as open-drain pull-down enables.

Top module: `i2c_srx_top`

## Requirements
- R1: After reset, no match flag, the full flag, the STOP flag, `scl_drive_low` and `sda_drive_low` are all 0.
- R2: The 7-bit address is matched against three slots (each slot has its own enable), general call 0x00 (gated by `gc_en`) and host address 0x08 (gated by `host_en`). At most one flag is set. When several sources hit, the winner follows the priority slot 0, slot 1, slot 2, general call, host.
- R3: The match flag is set on the rising edge of the ninth SCL clock of the address byte and is 0 before that edge.
- R4: During the ninth SCL clock of a matched address byte and of each following data byte, SDA is pulled low exactly when `ack_val` is 0. After an address that does not match, or one with the read bit set (R/W# = 1, bit 0 of the byte), SDA stays released and all bytes up to the next START are ignored.
- R5: A matched write address sets the full flag and loads the holding register with the address byte {address, 0}. Each data byte (first bit on the bus = bit 7) is loaded after its eighth clock and sets the full flag.
- R6: A cycle with `rd_en` high clears the full flag, unless a new byte sets it in the same cycle.
- R7: If the full flag is set when the seventh SCL clock of a data byte falls, SCL is held low from then on, before the eighth clock. It is released only by a read.
- R8: A STOP condition clears all match flags.
- R9: Any STOP condition sets the STOP flag, which stays set until `stop_clr` is pulsed. A byte still held after STOP stays readable.
- R10: A repeated START restarts address reception and leaves the STOP flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | SCL bus level |
| sda_in | input | 1 | SDA bus level |
| slot_addr | input | 21 | Three 7-bit address slots, slot k in bits [7k+6:7k] |
| slot_en | input | 3 | Per-slot enable |
| gc_en | input | 1 | General-call match enable |
| host_en | input | 1 | Host-address match enable |
| ack_val | input | 1 | Level driven in the acknowledge slot (0 = ACK) |
| rd_en | input | 1 | Read strobe for the holding register |
| stop_clr | input | 1 | Clears the STOP flag |
| rdata | output | 8 | Holding register contents |
| rx_full | output | 1 | Holding register full flag |
| match_slot | output | 3 | Per-slot match flags |
| match_gc | output | 1 | General-call match flag |
| match_host | output | 1 | Host-address match flag |
| stop_flag | output | 1 | Sticky STOP-seen flag |
| scl_drive_low | output | 1 | Pull SCL low when 1 |
| sda_drive_low | output | 1 | Pull SDA low when 1 |

## Verification
A wrong bit counter or shift register appears within one byte. It shows as a wrong acknowledge level on the ninth clock, a match flag that rises one clock early or late, or a wrong value in the holding register on the next read. Errors in the full-flag or stretch logic show on the bus within one byte: SCL is held when nothing is pending, or not held before the eighth clock. A stuck hold freezes the bus and is caught as a hang. Errors in the STOP handling show at the very next STOP, as match flags that stay set or a STOP flag that does not persist across a repeated START.

// File: rtl/i2c_srx_pkg.sv
package i2c_srx_pkg;
    localparam int ADDR_W = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_DATA,
        ST_DACK
    } srx_state_e;
endpackage

// File: rtl/i2c_srx_sync.sv
module i2c_srx_sync #(
    parameter int STAGES = 2,
    parameter int LINES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] lvl,
    output logic [LINES-1:0] rise,
    output logic [LINES-1:0] fall
);
    logic [STAGES-1:0] chain_q [LINES];
    logic [LINES-1:0]  prev_q;

    for (genvar i = 0; i < LINES; i++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q[i] <= '1;
                prev_q[i]  <= 1'b1;
            end else begin
                chain_q[i] <= {chain_q[i][STAGES-2:0], raw[i]};
                prev_q[i]  <= chain_q[i][STAGES-1];
            end
        end
        assign lvl[i]  = chain_q[i][STAGES-1];
        assign rise[i] = chain_q[i][STAGES-1] & ~prev_q[i];
        assign fall[i] = ~chain_q[i][STAGES-1] & prev_q[i];
    end
endmodule

// File: rtl/i2c_srx_match.sv
module i2c_srx_match
    import i2c_srx_pkg::*;
#(
    parameter int                NSLOT     = 3,
    parameter logic [ADDR_W-1:0] GC_ADDR   = 7'h00,
    parameter logic [ADDR_W-1:0] HOST_ADDR = 7'h08,
    localparam int               NM        = NSLOT + 2
) (
    input  logic [ADDR_W-1:0]       addr,
    input  logic [NSLOT*ADDR_W-1:0] slot_addr,
    input  logic [NSLOT-1:0]        slot_en,
    input  logic                    gc_en,
    input  logic                    host_en,
    output logic [NM-1:0]           hit
);
    logic [NM-1:0] raw;

    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        assign raw[k] = slot_en[k] && (addr == slot_addr[k*ADDR_W +: ADDR_W]);
    end
    assign raw[NSLOT]   = gc_en && (addr == GC_ADDR);
    assign raw[NSLOT+1] = host_en && (addr == HOST_ADDR);

    // lowest index wins
    assign hit = raw & (~raw + NM'(1));
endmodule

// File: rtl/i2c_srx_top.sv
module i2c_srx_top
    import i2c_srx_pkg::*;
#(
    parameter int                NSLOT       = 3,
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] GC_ADDR     = 7'h00,
    parameter logic [ADDR_W-1:0] HOST_ADDR   = 7'h08
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    scl_in,
    input  logic                    sda_in,
    input  logic [NSLOT*ADDR_W-1:0] slot_addr,
    input  logic [NSLOT-1:0]        slot_en,
    input  logic                    gc_en,
    input  logic                    host_en,
    input  logic                    ack_val,
    input  logic                    rd_en,
    input  logic                    stop_clr,
    output logic [7:0]              rdata,
    output logic                    rx_full,
    output logic [NSLOT-1:0]        match_slot,
    output logic                    match_gc,
    output logic                    match_host,
    output logic                    stop_flag,
    output logic                    scl_drive_low,
    output logic                    sda_drive_low
);
    localparam int NM      = NSLOT + 2;
    localparam int CNT_W   = 4;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(8);
    localparam logic [CNT_W-1:0] HOLD_BIT = CNT_W'(7);

    typedef struct packed {
        srx_state_e     st;
        logic [CNT_W-1:0] cnt;
        logic [7:0]     sh;
        logic [7:0]     dat;
        logic           full;
        logic           stopf;
        logic [NM-1:0]  match;
        logic [NM-1:0]  pend;
        logic           scl_low;
        logic           sda_low;
    } srx_regs_t;

    srx_regs_t q, d;

    logic [1:0] lvl, rise, fall;
    logic       scl_rise, scl_fall, start_ev, stop_ev;
    logic [NM-1:0] hit;

    i2c_srx_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  ({sda_in, scl_in}),
        .lvl  (lvl),
        .rise (rise),
        .fall (fall)
    );

    assign scl_rise = rise[0];
    assign scl_fall = fall[0];
    assign start_ev = fall[1] & lvl[0];
    assign stop_ev  = rise[1] & lvl[0];

    i2c_srx_match #(.NSLOT(NSLOT), .GC_ADDR(GC_ADDR), .HOST_ADDR(HOST_ADDR)) u_match (
        .addr     (q.sh[7:1]),
        .slot_addr(slot_addr),
        .slot_en  (slot_en),
        .gc_en    (gc_en),
        .host_en  (host_en),
        .hit      (hit)
    );

    always_comb begin
        d = q;
        if (rd_en) begin
            d.full    = 1'b0;
            d.scl_low = 1'b0;
        end
        if (stop_clr) d.stopf = 1'b0;

        if (start_ev) begin
            d.st      = ST_ADDR;
            d.cnt     = '0;
            d.match   = '0;
            d.pend    = '0;
            d.sda_low = 1'b0;
            d.scl_low = 1'b0;
        end else if (stop_ev) begin
            d.st      = ST_IDLE;
            d.match   = '0;
            d.stopf   = 1'b1;
            d.sda_low = 1'b0;
            d.scl_low = 1'b0;
        end else begin
            unique case (q.st)
                ST_ADDR: begin
                    if (scl_rise) begin
                        d.sh  = {q.sh[6:0], lvl[1]};
                        d.cnt = q.cnt + CNT_W'(1);
                    end else if (scl_fall && q.cnt == LAST_BIT) begin
                        if (hit != '0 && !q.sh[0]) begin
                            d.pend    = hit;
                            d.sda_low = !ack_val;
                            d.st      = ST_AACK;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                ST_AACK: begin
                    if (scl_rise) begin
                        d.match = q.pend;
                        d.dat   = q.sh;
                        d.full  = 1'b1;
                    end else if (scl_fall) begin
                        d.sda_low = 1'b0;
                        d.cnt     = '0;
                        d.st      = ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (scl_rise) begin
                        d.sh  = {q.sh[6:0], lvl[1]};
                        d.cnt = q.cnt + CNT_W'(1);
                    end else if (scl_fall) begin
                        if (q.cnt == HOLD_BIT && d.full) d.scl_low = 1'b1;
                        if (q.cnt == LAST_BIT) begin
                            d.dat     = q.sh;
                            d.full    = 1'b1;
                            d.sda_low = !ack_val;
                            d.st      = ST_DACK;
                        end
                    end
                end
                ST_DACK: begin
                    if (scl_fall) begin
                        d.sda_low = 1'b0;
                        d.cnt     = '0;
                        d.st      = ST_DATA;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign rdata         = q.dat;
    assign rx_full       = q.full;
    assign match_slot    = q.match[NSLOT-1:0];
    assign match_gc      = q.match[NSLOT];
    assign match_host    = q.match[NSLOT+1];
    assign stop_flag     = q.stopf;
    assign scl_drive_low = q.scl_low;
    assign sda_drive_low = q.sda_low;

    // R2
    one_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(q.match));
    // R8
    stop_clears_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (q.match == '0));
    // R9
    stop_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> q.stopf);
    // R7
    stretch_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.scl_low) |-> q.full);
    // R7
    stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.scl_low && !rd_en && !start_ev && !stop_ev) |=> q.scl_low);
    // R4
    ack_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.sda_low) |-> !$past(ack_val));
endmodule

// File: tb/tb_i2c_srx_top.sv
`timescale 1ns/100ps
module tb_i2c_srx_top;
    localparam int Q = 10;
    localparam int HOLD_WAIT = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic scl_m = 1'b1, sda_m = 1'b1;
    logic [20:0] slot_addr;
    logic [2:0]  slot_en;
    logic gc_en, host_en, ack_val, rd_en, stop_clr;
    logic [7:0] rdata;
    logic rx_full, match_gc, match_host, stop_flag, scl_drive_low, sda_drive_low;
    logic [2:0] match_slot;
    wire scl_bus = scl_m & ~scl_drive_low;
    wire sda_bus = sda_m & ~sda_drive_low;

    i2c_srx_top dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_bus), .sda_in(sda_bus),
        .slot_addr(slot_addr), .slot_en(slot_en), .gc_en(gc_en), .host_en(host_en),
        .ack_val(ack_val), .rd_en(rd_en), .stop_clr(stop_clr),
        .rdata(rdata), .rx_full(rx_full), .match_slot(match_slot),
        .match_gc(match_gc), .match_host(match_host), .stop_flag(stop_flag),
        .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low)
    );

    int nchk = 0, nfail = 0;
    logic [6:0] a_slot [3];
    logic ack_seen, pre7, pre8, late_en, held_at_read;
    logic [4:0] flags_before, flags_after;
    logic [7:0] late_val;

    function automatic logic [4:0] flags();
        return {match_host, match_gc, match_slot};
    endfunction

    // expected one-hot match vector, priority slot0..2, gc, host
    function automatic logic [4:0] exp_match(logic [6:0] a);
        logic [4:0] r = '0;
        for (int k = 0; k < 3; k++) if (slot_en[k] && a == a_slot[k]) r[k] = 1'b1;
        if (gc_en && a == 7'h00) r[3] = 1'b1;
        if (host_en && a == 7'h08) r[4] = 1'b1;
        return r & (~r + 5'd1);
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wq(int n); repeat (n) @(negedge clk); endtask

    task automatic do_read(output logic [7:0] v);
        @(negedge clk);
        v = rdata;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        wq(2);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(Q);
    endtask

    task automatic put_bit(logic b, int clk_no);
        int waited;
        sda_m = b; wq(Q);
        if (clk_no == 7) pre7 = scl_drive_low;
        if (clk_no == 8) pre8 = scl_drive_low;
        scl_m = 1'b1;
        waited = 0;
        while (scl_bus !== 1'b1) begin
            @(negedge clk);
            waited++;
            if (late_en && waited == HOLD_WAIT) begin
                held_at_read = scl_drive_low;
                do_read(late_val);
            end
        end
        wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic put_byte(logic [7:0] b);
        pre7 = 1'b0; pre8 = 1'b0;
        for (int i = 7; i >= 0; i--) put_bit(b[i], 8 - i);
        sda_m = 1'b1; wq(Q);
        flags_before = flags();
        scl_m = 1'b1; wq(Q);
        ack_seen = ~sda_bus;
        flags_after = flags();
        scl_m = 1'b0; wq(Q);
    endtask

    logic [7:0] v, d1, d2;
    int unsigned seed;

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin : main
        seed = $urandom(32'd4711);
        a_slot[0] = 7'h2A; a_slot[1] = 7'h35; a_slot[2] = 7'h51;
        slot_addr = {a_slot[2], a_slot[1], a_slot[0]};
        slot_en = 3'b111; gc_en = 1'b1; host_en = 1'b1; ack_val = 1'b0;
        rd_en = 1'b0; stop_clr = 1'b0; late_en = 1'b0;
        wq(5);
        chk("R1", "reset outputs", {flags(), rx_full, stop_flag, scl_drive_low, sda_drive_low}, '0);
        rst_n = 1'b1; wq(5);
        chk("R1", "after release", {flags(), rx_full, stop_flag, scl_drive_low, sda_drive_low}, '0);

        // directed: slot 1 write, two data bytes, second one overruns
        bus_start();
        put_byte({a_slot[1], 1'b0});
        chk("R3", "flags before 9th rise", flags_before, 5'b0);
        chk("R2", "slot1 flag", flags_after, 5'b00010);
        chk("R4", "address ACK", ack_seen, 1'b1);
        chk("R5", "full after address", rx_full, 1'b1);
        do_read(v);
        chk("R5", "first read is address byte", v, {a_slot[1], 1'b0});
        chk("R6", "read clears full", rx_full, 1'b0);
        d1 = 8'hC3; d2 = 8'h5A;
        put_byte(d1);
        chk("R4", "data ACK", ack_seen, 1'b1);
        chk("R7", "no stretch when empty", pre8, 1'b0);
        chk("R5", "full after data", rx_full, 1'b1);
        late_en = 1'b1; held_at_read = 1'b0;
        put_byte(d2);
        late_en = 1'b0;
        chk("R7", "no hold before 7th clock", pre7, 1'b0);
        chk("R7", "hold before 8th clock", pre8, 1'b1);
        chk("R7", "held until read", held_at_read, 1'b1);
        chk("R7", "late read value", late_val, d1);
        chk("R7", "released after read", scl_drive_low, 1'b0);
        bus_stop(); wq(4);
        chk("R8", "flags cleared by stop", flags(), 5'b0);
        chk("R9", "stop flag set", stop_flag, 1'b1);
        chk("R9", "pending after stop", rx_full, 1'b1);
        do_read(v);
        chk("R9", "data readable after stop", v, d2);

        // repeated START keeps stop flag; general call matched
        bus_start();
        put_byte(8'h00);
        chk("R2", "general call flag", flags_after, 5'b01000);
        do_read(v);
        bus_start();
        chk("R10", "stop flag survives restart", stop_flag, 1'b1);
        chk("R10", "flags cleared by restart", flags(), 5'b0);
        put_byte({7'h08, 1'b0});
        chk("R10", "host address after restart", flags_after, 5'b10000);
        do_read(v);
        chk("R10", "restart address byte", v, 8'h10);
        bus_stop(); wq(4);
        stop_clr = 1'b1; wq(1); stop_clr = 1'b0; wq(2);
        chk("R9", "stop flag cleared", stop_flag, 1'b0);

        // NACK level, disabled slot, read direction, unmatched then data
        ack_val = 1'b1;
        bus_start();
        put_byte({a_slot[0], 1'b0});
        chk("R4", "NACK when ack_val=1", ack_seen, 1'b0);
        chk("R2", "slot0 flag with NACK", flags_after, 5'b00001);
        do_read(v);
        bus_stop(); wq(4);
        ack_val = 1'b0;
        slot_en = 3'b011;
        bus_start();
        put_byte({a_slot[2], 1'b0});
        chk("R2", "disabled slot no flag", flags_after, 5'b0);
        chk("R4", "disabled slot no ACK", ack_seen, 1'b0);
        put_byte(8'hFF);
        chk("R4", "ignored byte no ACK", ack_seen, 1'b0);
        chk("R4", "ignored byte not loaded", rx_full, 1'b0);
        bus_stop(); wq(4);
        slot_en = 3'b111;
        bus_start();
        put_byte({a_slot[0], 1'b1});
        chk("R4", "read direction no ACK", ack_seen, 1'b0);
        chk("R4", "read direction no flag", flags_after, 5'b0);
        chk("R4", "read direction no full", rx_full, 1'b0);
        bus_stop(); wq(4);
        // priority: slot 2 equal to slot 0
        a_slot[2] = a_slot[0]; slot_addr = {a_slot[2], a_slot[1], a_slot[0]};
        bus_start();
        put_byte({a_slot[0], 1'b0});
        chk("R2", "priority slot0 over slot2", flags_after, 5'b00001);
        do_read(v);
        bus_stop(); wq(4);
        a_slot[2] = 7'h51; slot_addr = {a_slot[2], a_slot[1], a_slot[0]};
        stop_clr = 1'b1; wq(1); stop_clr = 1'b0;

        // random transfers
        for (int t = 0; t < 20; t++) begin
            logic [6:0] a;
            logic rw;
            logic [4:0] em;
            int nb;
            case ($urandom_range(0, 5))
                0: a = a_slot[0];
                1: a = a_slot[1];
                2: a = a_slot[2];
                3: a = 7'h00;
                4: a = 7'h08;
                default: a = 7'($urandom);
            endcase
            rw = ($urandom_range(0, 3) == 0);
            em = rw ? 5'b0 : exp_match(a);
            bus_start();
            put_byte({a, rw});
            chk("R2", "random match", flags_after, em);
            chk("R4", "random address ACK", ack_seen, em != 0);
            if (em != 0) begin
                do_read(v);
                chk("R5", "random address byte", v, {a, 1'b0});
            end
            nb = $urandom_range(1, 3);
            for (int b = 0; b < nb; b++) begin
                logic [7:0] x = 8'($urandom);
                put_byte(x);
                chk("R4", "random data ACK", ack_seen, em != 0);
                if (em != 0) begin
                    do_read(v);
                    chk("R5", "random data byte", v, x);
                end
            end
            bus_stop(); wq(4);
            chk("R8", "random stop clears flags", flags(), 5'b0);
            chk("R9", "random stop flag", stop_flag, 1'b1);
            stop_clr = 1'b1; wq(1); stop_clr = 1'b0; wq(1);
        end

        $display("  End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule